// File: doc/BRIEF.md
# Byte FIFO with Watermark Alerts

This block is a 64-deep, byte-wide first-in first-out buffer placed between a host-facing data port and an internal processing engine. One side pushes bytes, the other pops them, and both use a single-cycle strobe with no back-pressure. The oldest stored byte is always visible on the read data output, so a pop takes that byte in the cycle it is asserted.

The block reports how many bytes it holds as a 7-bit count (0 to 64). It keeps a sticky flag that records any byte lost to a write into a full buffer. It also drives two alert outputs, which feed an interrupt controller. Both alerts compare against a programmable 6-bit level. The high alert warns that little free space is left. The low alert warns that few bytes remain. A flush strobe empties the buffer in one cycle and clears the loss flag.

Top module: `alert_byte_fifo`

## Requirements
- R1: Bytes leave in the order they were pushed. While the count is non-zero, `rd_byte` shows the oldest stored byte in the same cycle, and a pop removes that byte at the next rising clock edge.
- R2: `fill_cnt` gives the number of stored bytes, from 0 to 64. It changes on the clock edge that accepts a push or a pop: +1 for an accepted push alone and −1 for a pop alone.
- R3: A flush strobe takes priority over push and pop in the same cycle. After that edge, `fill_cnt` is 0 and `lost_flag` is 0, and previously stored bytes can no longer be read.
- R4: After a flush, 64 new bytes can be pushed without setting `lost_flag`, and they read back unchanged.
- R5: A push while `fill_cnt` is 64 and no pop is asserted is dropped. It sets `lost_flag` at that edge and leaves the count and the stored data unchanged.
- R6: `lost_flag` stays at 1 across pushes and pops until a flush or reset.
- R7: `alert_hi` is 1 exactly when (64 − `fill_cnt`) ≤ `water_lvl`. It follows the count and the level with no extra delay.
- R8: `alert_lo` is 1 exactly when `fill_cnt` ≤ `water_lvl`. It follows the count and the level with no extra delay.
- R9: A pop while the count is 0 shows `rd_byte` = 00h and changes neither the count nor the pointers. The next byte pushed is the next byte read.
- R10: A push and a pop in the same cycle leave `fill_cnt` unchanged when the buffer is neither empty nor full. When the buffer is full, the push is accepted and `lost_flag` is not set.
- R11: While `rst_n` is low, `fill_cnt` is 0 and `lost_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and clear the loss flag |
| wr_stb | input | 1 | Push strobe |
| wr_byte | input | 8 | Byte to push |
| rd_stb | input | 1 | Pop strobe |
| rd_byte | output | 8 | Oldest stored byte; 00h when empty |
| water_lvl | input | 6 | Alert threshold |
| fill_cnt | output | 7 | Stored byte count |
| lost_flag | output | 1 | Sticky flag for a dropped push |
| alert_hi | output | 1 | Free space at or below the threshold |
| alert_lo | output | 1 | Count at or below the threshold |

## Verification
`rd_byte` is a same-cycle result: the bench compares it with the front of its scoreboard queue just after driving inputs at the falling edge, before the rising edge. `fill_cnt` and `lost_flag` are due one rising edge after the strobe, and the bench checks them one time unit after that edge. The alerts follow the count and the level without a register, so they are checked at the same instant against the scoreboard's own count. Inputs change only at falling edges, so no result depends on the order of events at the active edge.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef struct packed {
    logic take;
    logic give;
    logic drop;
  } fifo_op_t;
endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW:0]   count,
  output logic          empty,
  output logic          lost
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  fifo_op_t      op;
  logic          full;
  logic [AW-1:0] wp_n, rp_n;
  logic [CW-1:0] cnt_n;
  logic          lost_n;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_comb begin
    op.give = pop & ~empty;
    op.take = push & (~full | op.give);
    op.drop = push & ~op.take;
  end

  assign wr_en = op.take & ~flush;

  always_comb begin
    wp_n   = wr_ptr;
    rp_n   = rd_ptr;
    cnt_n  = count;
    lost_n = lost;
    if (flush) begin
      wp_n   = '0;
      rp_n   = '0;
      cnt_n  = '0;
      lost_n = 1'b0;
    end else begin
      if (op.take) wp_n = wr_ptr + AW'(1);
      if (op.give) rp_n = rd_ptr + AW'(1);
      case ({op.take, op.give})
        2'b10:   cnt_n = count + CW'(1);
        2'b01:   cnt_n = count - CW'(1);
        default: cnt_n = count;
      endcase
      if (op.drop) lost_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      lost   <= 1'b0;
    end else begin
      wr_ptr <= wp_n;
      rd_ptr <= rp_n;
      count  <= cnt_n;
      lost   <= lost_n;
    end
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fifo_alerts.sv
module fifo_alerts #(
  parameter int AW = 6
) (
  input  logic [AW:0]   count,
  input  logic [AW-1:0] level,
  output logic          hi,
  output logic          lo
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] space;
  logic [CW-1:0] lvl_w;

  always_comb begin
    space = CW'(DEPTH) - count;
    lvl_w = {1'b0, level};
    hi    = (space <= lvl_w);
    lo    = (count <= lvl_w);
  end
endmodule

// File: rtl/alert_byte_fifo.sv
module alert_byte_fifo #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_stb,
  output logic [DW-1:0] rd_byte,
  input  logic [AW-1:0] water_lvl,
  output logic [AW:0]   fill_cnt,
  output logic          lost_flag,
  output logic          alert_hi,
  output logic          alert_lo
);
  logic          wr_en;
  logic          empty;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] head;

  fifo_ctrl #(.AW(AW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .push   (wr_stb),
    .pop    (rd_stb),
    .wr_en  (wr_en),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .count  (fill_cnt),
    .empty  (empty),
    .lost   (lost_flag)
  );

  fifo_store #(.DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr),
    .wr_data (wr_byte),
    .rd_addr (rd_ptr),
    .rd_data (head)
  );

  fifo_alerts #(.AW(AW)) u_alert (
    .count (fill_cnt),
    .level (water_lvl),
    .hi    (alert_hi),
    .lo    (alert_lo)
  );

  assign rd_byte = empty ? '0 : head;
endmodule

// File: rtl/fifo_chk.sv
module fifo_chk #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [DW-1:0] rd_byte,
  input logic [AW:0]   fill_cnt,
  input logic          lost_flag,
  input logic          alert_hi,
  input logic          alert_lo
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  p_flush_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_cnt == '0) && !lost_flag);

  p_drop_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb && !flush && fill_cnt == CW'(DEPTH)) |=>
      lost_flag && fill_cnt == CW'(DEPTH));

  p_lost_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_flag && !flush) |=> lost_flag);

  p_full_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(DEPTH)) |-> alert_hi);

  p_empty_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == '0) |-> alert_lo);

  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == '0) |-> rd_byte == '0);

  p_both_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rd_stb && !flush && fill_cnt != '0 && fill_cnt != CW'(DEPTH))
      |=> $stable(fill_cnt));

  p_reset_r11: assert property (@(posedge clk)
    !rst_n |-> (fill_cnt == '0) && !lost_flag);
endmodule

bind alert_byte_fifo fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .rd_byte   (rd_byte),
  .fill_cnt  (fill_cnt),
  .lost_flag (lost_flag),
  .alert_hi  (alert_hi),
  .alert_lo  (alert_lo)
);

// File: tb/sim_alert_byte_fifo.sv
module sim_alert_byte_fifo;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_byte;
  logic [5:0] water_lvl = 6'd8;
  logic [6:0] fill_cnt;
  logic       lost_flag, alert_hi, alert_lo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] sb[$];
  bit         m_lost = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alert_byte_fifo u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte),
    .water_lvl(water_lvl), .fill_cnt(fill_cnt), .lost_flag(lost_flag),
    .alert_hi(alert_hi), .alert_lo(alert_lo)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    int n = sb.size();
    chk({tag, " count"}, fill_cnt, n);
    chk({tag, " lost"}, lost_flag, m_lost);
    chk({tag, " hi (R7)"}, alert_hi, ((64 - n) <= water_lvl));
    chk({tag, " lo (R8)"}, alert_lo, (n <= water_lvl));
  endtask

  // One clock cycle: drive at falling edge, monitor the head, update the scoreboard.
  task automatic cyc(bit p, logic [7:0] d, bit q, bit f, string tag);
    bit give, take;
    @(negedge clk);
    wr_stb = p; wr_byte = d; rd_stb = q; flush = f;
    #1;
    if (q) chk({tag, " head"}, rd_byte, (sb.size() == 0) ? 0 : sb[0]);
    if (f) begin
      sb.delete();
      m_lost = 0;
    end else begin
      give = q && sb.size() > 0;
      take = p && (sb.size() < 64 || give);
      if (p && !take) m_lost = 1;
      if (give) void'(sb.pop_front());
      if (take) sb.push_back(d);
    end
    @(posedge clk);
    #1;
    wr_stb = 0; rd_stb = 0; flush = 0;
    chk_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R11 count", fill_cnt, 0);
    chk("R11 lost", lost_flag, 0);
    chk("R11 rd_byte (R9)", rd_byte, 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R2: ordered fill and drain
    for (int i = 0; i < 10; i++) cyc(1, 8'(8'h10 + i), 0, 0, "R2 push");
    for (int i = 0; i < 5; i++)  cyc(0, 8'h00, 1, 0, "R1 pop");
    // R10: simultaneous push and pop mid-range
    for (int i = 0; i < 4; i++)  cyc(1, 8'(8'hA0 + i), 1, 0, "R10 both");
    for (int i = 0; i < 9; i++)  cyc(0, 8'h00, 1, 0, "R1 drain");
    // R9: pop on empty, then push/pop sequence intact
    cyc(0, 8'h00, 1, 0, "R9 empty pop");
    cyc(0, 8'h00, 1, 0, "R9 empty pop");
    cyc(1, 8'h5A, 1, 0, "R9 push with empty pop");
    cyc(0, 8'h00, 1, 0, "R9 follow");

    // Fill to full, sweeping alerts (R7, R8)
    water_lvl = 6'd20;
    for (int i = 0; i < 64; i++) cyc(1, 8'(i * 3 + 1), 0, 0, "R2 fill");
    // R5: overflow drop
    cyc(1, 8'hEE, 0, 0, "R5 drop");
    cyc(1, 8'hEF, 0, 0, "R5 drop");
    // R10: full with pop accepts push
    cyc(1, 8'hC3, 1, 0, "R10 full both");
    // R6: sticky across pops and pushes
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 1, 0, "R6 sticky");
    cyc(1, 8'h77, 0, 0, "R6 sticky");
    // R3: flush wins over push and pop
    cyc(1, 8'h99, 1, 1, "R3 flush");
    cyc(0, 8'h00, 1, 0, "R3 after flush");
    // R4: 64 bytes after flush, no loss
    water_lvl = 6'd0;
    for (int i = 0; i < 64; i++) cyc(1, 8'(8'hFF - i), 0, 0, "R4 refill");
    water_lvl = 6'd63;
    #1 chk_state("R7 lvl63");
    for (int i = 0; i < 64; i++) cyc(0, 8'h00, 1, 0, "R4 readback");
    water_lvl = 6'd0;
    #1 chk_state("R8 lvl0");

    // R11: reset mid-run
    cyc(1, 8'h42, 0, 0, "R2 push");
    @(negedge clk) rst_n = 1'b0;
    #1;
    sb.delete(); m_lost = 0;
    chk("R11 reset count", fill_cnt, 0);
    chk("R11 reset lost", lost_flag, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule